// File: doc/BRIEF.md
# LIN Slave Break Detector and Baud Rate Tracker

This block is the timing front end of a LIN slave node's receiver. It watches the serial receive line for a break, which is a low level lasting at least eleven bit periods. After the break it times the 0x55 sync character and derives the bit period in system clocks. The block then loads that period into its baud reload register, so that later data reception runs at the master's rate.

A two-bit state field records where the node stands in the frame: Sleep, Wait For Break, AutoBaud or Active. Software may write this field at any time, and the hardware advances it as a frame proceeds. Two flags are raised: break detect, and overrun for a sync measurement that does not fit. Both stay set until software clears them. A 4-bit break length field shows how far the last break ran past the eleven-bit threshold.

The receive input passes through a two-stage synchronizer. The system clock is expected to be at least 100 times the baud rate.

Top module: `lin_sync_tracker`

## Requirements
- R1: While slave mode is enabled and the state is Wait For Break (10b) or Active (11b), a low level on the synchronized receive line that lasts 11 whole bit periods sets the break flag. One bit period is `reload_o` clocks. A low level that ends before 11 bit periods sets nothing and leaves the state unchanged.
- R2: When a break is recognised, `brk_len_o` is set to 0. For each further whole bit period the line stays low, it rises by 1, up to a limit of 15. It holds its value until the next break.
- R3: When the line returns high after a recognised break, the state becomes AutoBaud (01b) if autobaud is enabled, and Active (11b) otherwise.
- R4: In AutoBaud with autobaud enabled, the block counts N system clocks from the first falling edge (start bit) to the fifth falling edge (start of data bit 7 of 0x55). It then loads (N+4)>>3 into `reload_o` and moves to Active.
- R5: `reload_o` holds a whole bit interval in system clocks, not a sixteenth of one. A software reload write loads `rld_wdata_i` directly.
- R6: If N+4 reaches 2^CNT_W, the overrun flag is set, `reload_o` is left unchanged and the state stays AutoBaud until software writes it.
- R7: A software state write takes effect on the next clock, ahead of any hardware transition. It discards any break or sync measurement in progress.
- R8: In Sleep (00b) with slave mode enabled, a falling edge on the receive line sets the break flag and the state stays Sleep.
- R9: Each flag is cleared by a pulse on its clear input. A set event in the same cycle wins over the clear.
- R10: While slave mode is disabled, the hardware neither changes the state nor sets either flag.
- R11: After reset the state is Wait For Break (10b), both flags and `brk_len_o` are 0, and `reload_o` equals RLD_INIT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | Serial receive line, idle high |
| slv_en_i | input | 1 | Slave mode enable |
| ab_en_i | input | 1 | Autobaud enable |
| st_wr_i | input | 1 | Software state write strobe |
| st_wdata_i | input | 2 | State value to write |
| rld_wr_i | input | 1 | Software reload write strobe |
| rld_wdata_i | input | CNT_W-3 | Reload value to write |
| clr_brk_i | input | 1 | Clear break flag |
| clr_ovr_i | input | 1 | Clear overrun flag |
| state_o | output | 2 | State field: 00 Sleep, 01 AutoBaud, 10 Wait For Break, 11 Active |
| brk_len_o | output | 4 | Bit periods beyond 11 in the last break, saturating at 15 |
| reload_o | output | CNT_W-3 | Baud reload value, full bit interval in clocks |
| brk_flag_o | output | 1 | Break detect / wake-up flag |
| ovr_flag_o | output | 1 | Autobaud overrun flag |

## Verification
The bench builds the block with CNT_W = 10 and RLD_INIT = 10. A 10-bit counter lets a bit period of 127 clocks reach the very edge of the reload range, where a sync stretched by 3 clocks still fits and one stretched by 4 overflows. It also lets a 130-clock period overrun the counter within a short run. Bit periods of 10 to 13 clocks keep each break short enough to cover the rounding cases, the length saturation and the abandoned break in a few thousand cycles.

// File: rtl/lin_sync_pkg.sv
package lin_sync_pkg;

  typedef enum logic [1:0] {
    ST_SLEEP    = 2'b00,
    ST_AUTOBAUD = 2'b01,
    ST_WAIT     = 2'b10,
    ST_ACTIVE   = 2'b11
  } lin_st_e;

  typedef enum logic [1:0] {
    AB_IDLE = 2'b00,
    AB_MEAS = 2'b01,
    AB_HALT = 2'b10
  } ab_ph_e;

  localparam int unsigned BRK_MIN_BITS = 11;
  localparam int unsigned LEN_MAX      = 15;
  localparam int unsigned SYNC_LAST_FALL = 4; // falls counted before the closing one

endpackage

// File: rtl/lin_rx_sync.sv
module lin_rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_i,
  output logic rx_s_o,
  output logic fall_o
);

  logic [STAGES-1:0] sh_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '1;
      prev_q <= 1'b1;
    end else begin
      sh_q   <= {sh_q[STAGES-2:0], rx_i};
      prev_q <= sh_q[STAGES-1];
    end
  end

  assign rx_s_o = sh_q[STAGES-1];
  assign fall_o = prev_q & ~sh_q[STAGES-1];

endmodule

// File: rtl/lin_break_det.sv
module lin_break_det
  import lin_sync_pkg::*;
#(
  parameter int unsigned RW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic          clr_i,
  input  logic          rx_s_i,
  input  logic [RW-1:0] per_i,
  output logic          hit_o,
  output logic          end_o,
  output logic [3:0]    len_o
);

  localparam int unsigned NB_SAT = BRK_MIN_BITS + LEN_MAX;
  localparam int unsigned LB_W   = $clog2(NB_SAT + 1);

  logic [RW-1:0]   tmr_q, tmr_d, per_m1;
  logic [LB_W-1:0] nb_q, nb_d, nb_inc, over;
  logic            seen_q, seen_d, hit_q, hit_d, end_q, end_d;
  logic [3:0]      len_q, len_d;

  assign per_m1 = (per_i == '0) ? '0 : per_i - 1'b1;
  assign nb_inc = (nb_q == LB_W'(NB_SAT)) ? nb_q : nb_q + 1'b1;
  assign over   = nb_inc - LB_W'(BRK_MIN_BITS);

  always_comb begin
    tmr_d  = tmr_q;
    nb_d   = nb_q;
    seen_d = seen_q;
    len_d  = len_q;
    hit_d  = 1'b0;
    end_d  = 1'b0;
    if (clr_i || !en_i) begin
      tmr_d  = '0;
      nb_d   = '0;
      seen_d = 1'b0;
    end else if (!rx_s_i) begin
      if (tmr_q == per_m1) begin
        tmr_d = '0;
        nb_d  = nb_inc;
        if (nb_inc == LB_W'(BRK_MIN_BITS) && nb_q != nb_inc) begin
          hit_d  = 1'b1;
          seen_d = 1'b1;
          len_d  = '0;
        end else if (nb_inc > LB_W'(BRK_MIN_BITS)) begin
          len_d = over[3:0];
        end
      end else begin
        tmr_d = tmr_q + 1'b1;
      end
    end else begin
      tmr_d = '0;
      nb_d  = '0;
      if (seen_q) begin
        end_d  = 1'b1;
        seen_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q  <= '0;
      nb_q   <= '0;
      seen_q <= 1'b0;
      hit_q  <= 1'b0;
      end_q  <= 1'b0;
      len_q  <= '0;
    end else begin
      tmr_q  <= tmr_d;
      nb_q   <= nb_d;
      seen_q <= seen_d;
      hit_q  <= hit_d;
      end_q  <= end_d;
      len_q  <= len_d;
    end
  end

  assign hit_o = hit_q;
  assign end_o = end_q;
  assign len_o = len_q;

  AST_HIT_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    hit_q |-> $past(!rx_s_i && en_i)); // R1
  AST_END_ON_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    end_q |-> $past(rx_s_i)); // R3
  AST_LEN_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hit_q) |-> len_q == 4'd0); // R2

endmodule

// File: rtl/lin_autobaud.sv
module lin_autobaud
  import lin_sync_pkg::*;
#(
  parameter int unsigned CW = 16,
  parameter int unsigned RW = CW - 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_i,
  input  logic          fall_i,
  output logic          done_o,
  output logic          ovf_o,
  output logic [RW-1:0] val_o
);

  ab_ph_e        ph_q, ph_d;
  logic [2:0]    nf_q, nf_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW:0]   sum;
  logic [RW:0]   rnd;
  logic          done_d, ovf_d, done_q, ovf_q;
  logic [RW-1:0] val_q, val_d;

  // count holds N-1 when the closing edge arrives; +1 for N, +4 for rounding
  assign sum = {1'b0, cnt_q} + (CW+1)'(5);
  assign rnd = sum[CW:3];

  always_comb begin
    ph_d   = ph_q;
    nf_d   = nf_q;
    cnt_d  = cnt_q;
    val_d  = val_q;
    done_d = 1'b0;
    ovf_d  = 1'b0;
    if (!run_i) begin
      ph_d  = AB_IDLE;
      nf_d  = '0;
      cnt_d = '0;
    end else begin
      unique case (ph_q)
        AB_IDLE: if (fall_i) begin
          ph_d  = AB_MEAS;
          nf_d  = 3'd1;
          cnt_d = '0;
        end
        AB_MEAS: begin
          if (fall_i && nf_q == 3'(SYNC_LAST_FALL)) begin
            ph_d = AB_HALT;
            if (rnd[RW]) ovf_d = 1'b1;
            else begin
              done_d = 1'b1;
              val_d  = rnd[RW-1:0];
            end
          end else if (cnt_q == '1) begin
            ph_d  = AB_HALT;
            ovf_d = 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
            if (fall_i) nf_d = nf_q + 1'b1;
          end
        end
        default: ph_d = AB_HALT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= AB_IDLE;
      nf_q   <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
      ovf_q  <= 1'b0;
      val_q  <= '0;
    end else begin
      ph_q   <= ph_d;
      nf_q   <= nf_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
      ovf_q  <= ovf_d;
      val_q  <= val_d;
    end
  end

  assign done_o = done_q;
  assign ovf_o  = ovf_q;
  assign val_o  = val_q;

  AST_DONE_OVF_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_q && ovf_q)); // R6
  AST_MEAS_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == AB_MEAS) |-> $past(run_i)); // R4

endmodule

// File: rtl/lin_sync_tracker.sv
module lin_sync_tracker
  import lin_sync_pkg::*;
#(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned RLD_INIT = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_i,
  input  logic             slv_en_i,
  input  logic             ab_en_i,
  input  logic             st_wr_i,
  input  logic [1:0]       st_wdata_i,
  input  logic             rld_wr_i,
  input  logic [CNT_W-4:0] rld_wdata_i,
  input  logic             clr_brk_i,
  input  logic             clr_ovr_i,
  output logic [1:0]       state_o,
  output logic [3:0]       brk_len_o,
  output logic [CNT_W-4:0] reload_o,
  output logic             brk_flag_o,
  output logic             ovr_flag_o
);

  localparam int unsigned RLD_W = CNT_W - 3;

  logic [1:0]       rs_q;
  logic             rst_sn;
  lin_st_e          st_q, st_d;
  logic [RLD_W-1:0] rld_q, rld_d, ab_val;
  logic             brk_q, brk_d, ovr_q, ovr_d;
  logic             rx_s, fall, hit, brk_end, done, ovf, det_en, ab_run, wake;

  // reset asserts at once, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sn = rs_q[1];

  lin_rx_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_sn), .rx_i(rx_i), .rx_s_o(rx_s), .fall_o(fall)
  );

  assign det_en = slv_en_i && (st_q == ST_WAIT || st_q == ST_ACTIVE);

  lin_break_det #(.RW(RLD_W)) u_brk (
    .clk(clk), .rst_n(rst_sn), .en_i(det_en), .clr_i(st_wr_i),
    .rx_s_i(rx_s), .per_i(rld_q), .hit_o(hit), .end_o(brk_end), .len_o(brk_len_o)
  );

  assign ab_run = slv_en_i && ab_en_i && (st_q == ST_AUTOBAUD) && !st_wr_i;

  lin_autobaud #(.CW(CNT_W), .RW(RLD_W)) u_ab (
    .clk(clk), .rst_n(rst_sn), .run_i(ab_run), .fall_i(fall),
    .done_o(done), .ovf_o(ovf), .val_o(ab_val)
  );

  assign wake = slv_en_i && (st_q == ST_SLEEP) && fall;

  always_comb begin
    st_d = st_q;
    if (st_wr_i) begin
      st_d = lin_st_e'(st_wdata_i);
    end else if (slv_en_i) begin
      unique case (st_q)
        ST_WAIT, ST_ACTIVE: if (brk_end) st_d = ab_en_i ? ST_AUTOBAUD : ST_ACTIVE;
        ST_AUTOBAUD:        if (done)    st_d = ST_ACTIVE;
        default:            st_d = st_q;
      endcase
    end
  end

  always_comb begin
    brk_d = brk_q;
    if (clr_brk_i)             brk_d = 1'b0;
    if (slv_en_i && (hit || wake)) brk_d = 1'b1;
    ovr_d = ovr_q;
    if (clr_ovr_i)             ovr_d = 1'b0;
    if (slv_en_i && ovf)       ovr_d = 1'b1;
    rld_d = rld_q;
    if (rld_wr_i)              rld_d = rld_wdata_i;
    else if (slv_en_i && done) rld_d = ab_val;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      st_q  <= ST_WAIT;
      brk_q <= 1'b0;
      ovr_q <= 1'b0;
      rld_q <= RLD_W'(RLD_INIT);
    end else begin
      st_q  <= st_d;
      brk_q <= brk_d;
      ovr_q <= ovr_d;
      rld_q <= rld_d;
    end
  end

  assign state_o    = st_q;
  assign reload_o   = rld_q;
  assign brk_flag_o = brk_q;
  assign ovr_flag_o = ovr_q;

  AST_RELOAD_HOLD_ON_OVF: assert property (@(posedge clk) disable iff (!rst_sn)
    (ovf && !rld_wr_i) |=> $stable(reload_o)); // R6
  AST_OVR_CAUSE: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(ovr_flag_o) |-> $past(ovf)); // R6
  AST_AB_EXIT: assert property (@(posedge clk) disable iff (!rst_sn)
    (st_q == ST_AUTOBAUD && !st_wr_i) |=> (st_q == ST_AUTOBAUD || st_q == ST_ACTIVE)); // R4
  AST_SLEEP_HOLD: assert property (@(posedge clk) disable iff (!rst_sn)
    (st_q == ST_SLEEP && !st_wr_i) |=> st_q == ST_SLEEP); // R8
  AST_NO_HW_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_sn)
    (!slv_en_i && !st_wr_i) |=> $stable(state_o)); // R10

endmodule

// File: tb/lin_sync_tracker_bench.sv
module lin_sync_tracker_bench;

  localparam int unsigned CNT_W = 10;
  localparam int unsigned RW    = CNT_W - 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rx = 1'b1, slv_en = 1'b1, ab_en = 1'b1;
  logic          st_wr = 1'b0, rld_wr = 1'b0, clr_brk = 1'b0, clr_ovr = 1'b0;
  logic [1:0]    st_wdata = 2'b00;
  logic [RW-1:0] rld_wdata = '0;
  logic [1:0]    state;
  logic [3:0]    brk_len;
  logic [RW-1:0] reload;
  logic          brk_flag, ovr_flag;

  int n_chk = 0, n_fail = 0, exp_rld = 10;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  lin_sync_tracker #(.CNT_W(CNT_W), .RLD_INIT(10)) u_lin_sync_tracker (
    .clk(clk), .rst_n(rst_n), .rx_i(rx), .slv_en_i(slv_en), .ab_en_i(ab_en),
    .st_wr_i(st_wr), .st_wdata_i(st_wdata), .rld_wr_i(rld_wr), .rld_wdata_i(rld_wdata),
    .clr_brk_i(clr_brk), .clr_ovr_i(clr_ovr), .state_o(state), .brk_len_o(brk_len),
    .reload_o(reload), .brk_flag_o(brk_flag), .ovr_flag_o(ovr_flag)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic write_state(input logic [1:0] v);
    st_wdata = v; st_wr = 1'b1; wait_clk(1); st_wr = 1'b0; wait_clk(1);
  endtask

  task automatic clear_flags;
    clr_brk = 1'b1; clr_ovr = 1'b1; wait_clk(1); clr_brk = 1'b0; clr_ovr = 1'b0; wait_clk(1);
  endtask

  // low for lb whole bit periods plus half a period, then high
  task automatic send_break(input int lb);
    rx = 1'b0; wait_clk(lb * exp_rld + exp_rld / 2);
    rx = 1'b1; wait_clk(10);
  endtask

  // 0x55 LSB first framed by start and stop; extra clocks stretch data bit 6
  task automatic send_sync(input int p, input int extra);
    for (int i = 0; i < 10; i++) begin
      if (i == 0)      rx = 1'b0;
      else if (i == 9) rx = 1'b1;
      else             rx = (8'h55 >> (i - 1)) & 1;
      wait_clk(p + ((i == 7) ? extra : 0));
    end
    wait_clk(10);
  endtask

  task automatic t_reset;
    chk("R11", "state", state, 2);
    chk("R11", "brk_flag", brk_flag, 0);
    chk("R11", "ovr_flag", ovr_flag, 0);
    chk("R11", "brk_len", brk_len, 0);
    chk("R11", "reload", reload, 10);
  endtask

  task automatic t_short_low;
    send_break(10);
    chk("R1", "no flag after 10 bits", brk_flag, 0);
    chk("R1", "state held", state, 2);
  endtask

  task automatic t_first_frame;
    send_break(13);
    chk("R1", "break flag", brk_flag, 1);
    chk("R2", "length 13 bits", brk_len, 2);
    chk("R3", "to autobaud", state, 1);
    send_sync(12, 0);
    exp_rld = 12;
    chk("R4", "state active", state, 3);
    chk("R5", "full bit reload", reload, 12);
    clear_flags();
    chk("R9", "break flag cleared", brk_flag, 0);
  endtask

  task automatic t_rounding;
    send_break(30);
    chk("R2", "length saturates", brk_len, 15);
    chk("R3", "active to autobaud", state, 1);
    send_sync(12, 3);
    chk("R4", "N=99 rounds to 12", reload, 12);
    send_break(12);
    chk("R2", "length 12 bits", brk_len, 1);
    send_sync(12, 4);
    exp_rld = 13;
    chk("R4", "N=100 rounds to 13", reload, 13);
    chk("R4", "state active", state, 3);
  endtask

  task automatic t_no_autobaud;
    ab_en = 1'b0;
    send_break(14);
    chk("R3", "straight to active", state, 3);
    chk("R2", "length 14 bits", brk_len, 3);
    send_sync(12, 0);
    chk("R3", "reload unchanged", reload, 13);
    ab_en = 1'b1;
    rld_wdata = 7'd10; rld_wr = 1'b1; wait_clk(1); rld_wr = 1'b0; wait_clk(1);
    exp_rld = 10;
    chk("R5", "software reload", reload, 10);
    clear_flags();
  endtask

  task automatic t_overflow;
    send_break(12);
    send_sync(127, 3);
    exp_rld = 127;
    chk("R6", "edge fits", reload, 127);
    chk("R6", "no overrun at edge", ovr_flag, 0);
    send_break(12);
    send_sync(127, 4);
    chk("R6", "overrun flag", ovr_flag, 1);
    chk("R6", "reload kept", reload, 127);
    chk("R6", "stays autobaud", state, 1);
    write_state(2'b10);
    chk("R7", "sw write to wait", state, 2);
    clear_flags();
    chk("R9", "overrun cleared", ovr_flag, 0);
    rld_wdata = 7'd10; rld_wr = 1'b1; wait_clk(1); rld_wr = 1'b0; wait_clk(1);
    exp_rld = 10;
  endtask

  task automatic t_abandon;
    rx = 1'b0; wait_clk(105);
    write_state(2'b10);
    wait_clk(60);
    rx = 1'b1; wait_clk(10);
    chk("R7", "restarted break not seen", brk_flag, 0);
    chk("R7", "state wait", state, 2);
  endtask

  task automatic t_sleep;
    write_state(2'b00);
    rx = 1'b0; wait_clk(6); rx = 1'b1; wait_clk(10);
    chk("R8", "wake flag", brk_flag, 1);
    chk("R8", "stays sleep", state, 0);
    clear_flags();
  endtask

  task automatic t_disabled;
    write_state(2'b10);
    slv_en = 1'b0;
    send_break(15);
    chk("R10", "no flag", brk_flag, 0);
    chk("R10", "state held", state, 2);
    slv_en = 1'b1;
  endtask

  initial begin
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    t_reset();
    t_short_low();
    t_first_frame();
    t_rounding();
    t_no_autobaud();
    t_overflow();
    t_abandon();
    t_sleep();
    t_disabled();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule